// File: doc/BRIEF.md
# Receive DMA context control and command pointer registers

This block keeps the per-context control and status word of a descriptor-driven receive DMA engine, together with the pointer to the first descriptor of the context program. Software never writes the control word directly. Writing to one alias sets every bit where the write data holds a one. Writing to the other alias clears every such bit. Both aliases read back the same current value, so software can change chosen bits without a read-modify-write and cannot race the hardware updates.

The DMA engine drives the hardware side. A descriptor fetch drops the resume request (wake). A fatal error marks the context dead. A busy level reports that processing is in progress (active). A packet-status strobe records the speed and the completion code of the last received packet. The engine takes the run and wake bits and the command pointer from the block. The command pointer splits into a 16-byte-aligned descriptor address and a small Z field that tells whether the program has any descriptors.

Top module: `ctx_ctrl_regs`

## Requirements
- R1: A write to word address 0 (set alias) sets run (bit 15) and wake (bit 12) wherever the write data holds a one. Zero bits leave those bits unchanged.
- R2: A write to word address 1 (clear alias) clears run (bit 15) and wake (bit 12) wherever the write data holds a one. Zero bits leave those bits unchanged.
- R3: Reads at address 0 and address 1 both return the same word: run at bit 15, wake at 12, dead at 11, active at 10, speed at 7:5 and event code at 4:0. Bits 31:16, 14:13 and 9:8 read as zero.
- R4: Run changes only through software writes. hw_fetch, hw_fatal, hw_busy and pkt_stb never alter it.
- R5: Wake is cleared in the cycle after hw_fetch is high. If a set-alias write with bit 12 at one happens in the same cycle, wake ends up at one.
- R6: Dead becomes one in the cycle after hw_fatal. A clear-alias write with bit 15 at one clears dead, and this wins over a hw_fatal in the same cycle. Writes to bit 11 at either alias have no effect.
- R7: Active equals the value hw_busy had in the previous cycle. Writes to bit 10 at either alias have no effect.
- R8: Speed (000 = 100 Mb/s, 001 = 200 Mb/s, 010 = 400 Mb/s, other codes reserved) and event code are loaded together from pkt_speed and pkt_evt in the cycle after pkt_stb. Otherwise they hold, and software writes do not alter them.
- R9: A write to word address 3 stores all 32 bits of the command pointer, and a read there returns them. cmd_addr carries bits 31:4 and cmd_z carries bits 3:0. Control-alias writes leave the pointer unchanged.
- R10: While rst_n is low every stored bit is zero, so all reads and outputs are zero. The release is synchronised through SYNC_STAGES flops (default 2).
- R11: Word address 2 reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hw_fetch | input | 1 | Engine fetched a descriptor |
| hw_fatal | input | 1 | Engine hit a fatal error |
| hw_busy | input | 1 | Engine is processing descriptors |
| pkt_stb | input | 1 | Packet status valid |
| pkt_speed | input | 3 | Speed code of the received packet |
| pkt_evt | input | 5 | Completion or error code of the packet |
| ctx_run | output | 1 | Run bit to the engine |
| ctx_wake | output | 1 | Wake bit to the engine |
| cmd_addr | output | 28 | Descriptor address, bits 31:4 of the command pointer |
| cmd_z | output | 4 | Z field, bits 3:0 of the command pointer |

## Verification
The assertions check the following on every cycle:
- run moves only on control-alias writes;
- the fetch and fatal side effects, including both same-cycle priorities;
- active tracking hw_busy;
- the status fields loading and holding only on the strobe;
- the pointer holding between its own writes;
- reserved bits reading zero.

Other behaviour only the bench scenarios can show. These are that both aliases return the identical word, the full set and clear sweep over every mix of control bits, and every speed and code pair. They also include the walking-one contents of the pointer, and that the unused address and the read-only fields ignore writes.

// File: rtl/ctx_ctrl_pkg.sv
package ctx_ctrl_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned SPD_W  = 3;
  localparam int unsigned EVT_W  = 5;
  localparam int unsigned Z_W    = 4;
  localparam int unsigned PTR_W  = REG_W - Z_W;

  localparam int unsigned RUN_B  = 15;
  localparam int unsigned WAKE_B = 12;
  localparam int unsigned DEAD_B = 11;
  localparam int unsigned ACT_B  = 10;
  localparam int unsigned SPD_LO = 5;
  localparam int unsigned EVT_LO = 0;

  localparam logic [ADDR_W-1:0] ADR_SET = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CLR = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_GAP = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_PTR = 2'd3;

  // bits of the control word that carry state; the rest read as zero
  localparam logic [REG_W-1:0] LIVE_MASK =
      (REG_W'(1) << RUN_B) | (REG_W'(1) << WAKE_B) |
      (REG_W'(1) << DEAD_B) | (REG_W'(1) << ACT_B) |
      (((REG_W'(1) << SPD_W) - REG_W'(1)) << SPD_LO) |
      (((REG_W'(1) << EVT_W) - REG_W'(1)) << EVT_LO);

  typedef struct packed {
    logic run;
    logic wake;
    logic dead;
    logic active;
  } ctl_bits_t;

  typedef struct packed {
    logic [SPD_W-1:0] spd;
    logic [EVT_W-1:0] evt;
  } pkt_stat_t;

endpackage

// File: rtl/ctx_rst_sync.sv
module ctx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stg_d;
    if (i == 0) begin : g_first
      assign stg_d = 1'b1;
    end else begin : g_next
      assign stg_d = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n_in) begin
      if (!rst_n_in) begin
        stg_q[i] <= 1'b0;
      end else begin
        stg_q[i] <= stg_d;
      end
    end
  end

  assign rst_n_out = stg_q[STAGES-1];

endmodule

// File: rtl/ctx_ctl_bits.sv
module ctx_ctl_bits
  import ctx_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sw_set_run,
  input  logic      sw_clr_run,
  input  logic      sw_set_wake,
  input  logic      sw_clr_wake,
  input  logic      hw_fetch,
  input  logic      hw_fatal,
  input  logic      hw_busy,
  output ctl_bits_t ctl_q
);

  ctl_bits_t ctl_d;
  logic      ctl_en;

  always_comb begin
    ctl_d = ctl_q;

    // run: software only
    if (sw_set_run) ctl_d.run = 1'b1;
    if (sw_clr_run) ctl_d.run = 1'b0;

    // wake: a software set beats a fetch in the same cycle
    if (hw_fetch || sw_clr_wake) ctl_d.wake = 1'b0;
    if (sw_set_wake)             ctl_d.wake = 1'b1;

    // dead: a software stop beats a fatal error in the same cycle
    if (hw_fatal)   ctl_d.dead = 1'b1;
    if (sw_clr_run) ctl_d.dead = 1'b0;

    // active: follows the engine busy level
    ctl_d.active = hw_busy;
  end

  assign ctl_en = sw_set_run | sw_clr_run | sw_set_wake | sw_clr_wake |
                  hw_fetch | hw_fatal | (hw_busy != ctl_q.active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/ctx_pkt_status.sv
module ctx_pkt_status
  import ctx_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stat_ld,
  input  pkt_stat_t stat_d,
  output pkt_stat_t stat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ld) begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/ctx_cmd_ptr.sv
module ctx_cmd_ptr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ptr_ld,
  input  logic [W-1:0] ptr_d,
  output logic [W-1:0] ptr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_ld) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/ctx_ctrl_regs.sv
module ctx_ctrl_regs
  import ctx_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              hw_fetch,
  input  logic              hw_fatal,
  input  logic              hw_busy,
  input  logic              pkt_stb,
  input  logic [SPD_W-1:0]  pkt_speed,
  input  logic [EVT_W-1:0]  pkt_evt,
  output logic              ctx_run,
  output logic              ctx_wake,
  output logic [PTR_W-1:0]  cmd_addr,
  output logic [Z_W-1:0]    cmd_z
);

  logic             rst_q_n;
  logic             wr_set;
  logic             wr_clr;
  logic             wr_ptr;
  ctl_bits_t        ctl_q;
  pkt_stat_t        stat_d;
  pkt_stat_t        stat_q;
  logic [REG_W-1:0] ptr_q;
  logic [REG_W-1:0] rd_ctl;
  logic             st_dead;
  logic             st_active;
  logic [SPD_W-1:0] st_spd;
  logic [EVT_W-1:0] st_evt;

  ctx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  // write decode
  assign wr_set = reg_wr && (reg_addr == ADR_SET);
  assign wr_clr = reg_wr && (reg_addr == ADR_CLR);
  assign wr_ptr = reg_wr && (reg_addr == ADR_PTR);

  ctx_ctl_bits u_ctl (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .sw_set_run  (wr_set && reg_wdata[RUN_B]),
    .sw_clr_run  (wr_clr && reg_wdata[RUN_B]),
    .sw_set_wake (wr_set && reg_wdata[WAKE_B]),
    .sw_clr_wake (wr_clr && reg_wdata[WAKE_B]),
    .hw_fetch    (hw_fetch),
    .hw_fatal    (hw_fatal),
    .hw_busy     (hw_busy),
    .ctl_q       (ctl_q)
  );

  assign stat_d.spd = pkt_speed;
  assign stat_d.evt = pkt_evt;

  ctx_pkt_status u_stat (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .stat_ld (pkt_stb),
    .stat_d  (stat_d),
    .stat_q  (stat_q)
  );

  ctx_cmd_ptr #(.W(REG_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .ptr_ld (wr_ptr),
    .ptr_d  (reg_wdata),
    .ptr_q  (ptr_q)
  );

  assign st_dead   = ctl_q.dead;
  assign st_active = ctl_q.active;
  assign st_spd    = stat_q.spd;
  assign st_evt    = stat_q.evt;

  // control word assembly and read mux
  always_comb begin
    rd_ctl                    = '0;
    rd_ctl[RUN_B]             = ctl_q.run;
    rd_ctl[WAKE_B]            = ctl_q.wake;
    rd_ctl[DEAD_B]            = ctl_q.dead;
    rd_ctl[ACT_B]             = ctl_q.active;
    rd_ctl[SPD_LO +: SPD_W]   = stat_q.spd;
    rd_ctl[EVT_LO +: EVT_W]   = stat_q.evt;
  end

  always_comb begin
    case (reg_addr)
      ADR_SET, ADR_CLR: reg_rdata = rd_ctl;
      ADR_PTR:          reg_rdata = ptr_q;
      default:          reg_rdata = '0;
    endcase
  end

  assign ctx_run  = ctl_q.run;
  assign ctx_wake = ctl_q.wake;
  assign cmd_addr = ptr_q[REG_W-1:Z_W];
  assign cmd_z    = ptr_q[Z_W-1:0];

endmodule

// File: rtl/ctx_ctrl_chk.sv
module ctx_ctrl_chk
  import ctx_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              hw_fetch,
  input logic              hw_fatal,
  input logic              hw_busy,
  input logic              pkt_stb,
  input logic [SPD_W-1:0]  pkt_speed,
  input logic [EVT_W-1:0]  pkt_evt,
  input logic              ctx_run,
  input logic              ctx_wake,
  input logic [PTR_W-1:0]  cmd_addr,
  input logic [Z_W-1:0]    cmd_z,
  input logic              st_dead,
  input logic              st_active,
  input logic [SPD_W-1:0]  st_spd,
  input logic [EVT_W-1:0]  st_evt
);

  logic set_w;
  logic clr_w;
  assign set_w = reg_wr && (reg_addr == ADR_SET);
  assign clr_w = reg_wr && (reg_addr == ADR_CLR);

  a_r1_run_set: assert property (@(posedge clk) disable iff (!rst_q_n)
    (set_w && reg_wdata[RUN_B]) |=> ctx_run);

  a_r2_run_clr: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_w && reg_wdata[RUN_B]) |=> !ctx_run);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (set_w || clr_w || reg_addr == ADR_SET || reg_addr == ADR_CLR) |->
      ((reg_rdata & ~LIVE_MASK) == '0));

  a_r4_run_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !((set_w || clr_w) && reg_wdata[RUN_B]) |=> $stable(ctx_run));

  a_r5_wake_fetch: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hw_fetch && !(set_w && reg_wdata[WAKE_B])) |=> !ctx_wake);

  a_r5_wake_set_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (set_w && reg_wdata[WAKE_B]) |=> ctx_wake);

  a_r6_dead_fatal: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hw_fatal && !(clr_w && reg_wdata[RUN_B])) |=> st_dead);

  a_r6_dead_stop: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_w && reg_wdata[RUN_B]) |=> !st_dead);

  a_r7_active_on: assert property (@(posedge clk) disable iff (!rst_q_n)
    hw_busy |=> st_active);

  a_r7_active_off: assert property (@(posedge clk) disable iff (!rst_q_n)
    !hw_busy |=> !st_active);

  a_r8_status_load: assert property (@(posedge clk) disable iff (!rst_q_n)
    pkt_stb |=> (st_spd == $past(pkt_speed)) && (st_evt == $past(pkt_evt)));

  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pkt_stb |=> ($stable(st_spd) && $stable(st_evt)));

  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(reg_wr && reg_addr == ADR_PTR) |=> ($stable(cmd_addr) && $stable(cmd_z)));

  a_r11_gap_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_addr == ADR_GAP) |-> (reg_rdata == '0));

endmodule

bind ctx_ctrl_regs ctx_ctrl_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .hw_fetch  (hw_fetch),
  .hw_fatal  (hw_fatal),
  .hw_busy   (hw_busy),
  .pkt_stb   (pkt_stb),
  .pkt_speed (pkt_speed),
  .pkt_evt   (pkt_evt),
  .ctx_run   (ctx_run),
  .ctx_wake  (ctx_wake),
  .cmd_addr  (cmd_addr),
  .cmd_z     (cmd_z),
  .st_dead   (st_dead),
  .st_active (st_active),
  .st_spd    (st_spd),
  .st_evt    (st_evt)
);

// File: tb/ctx_ctrl_regs_tb.sv
`timescale 1ns/1ps
module ctx_ctrl_regs_tb;

  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        hw_fetch, hw_fatal, hw_busy, pkt_stb;
  logic [2:0]  pkt_speed;
  logic [4:0]  pkt_evt;
  logic        ctx_run, ctx_wake;
  logic [27:0] cmd_addr;
  logic [3:0]  cmd_z;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model, built from the requirements
  bit          m_run, m_wake, m_dead, m_act;
  bit [2:0]    m_spd;
  bit [4:0]    m_evt;
  bit [31:0]   m_ptr;

  always #(HALF) clk = ~clk;

  ctx_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_fetch(hw_fetch),
    .hw_fatal(hw_fatal), .hw_busy(hw_busy), .pkt_stb(pkt_stb),
    .pkt_speed(pkt_speed), .pkt_evt(pkt_evt), .ctx_run(ctx_run),
    .ctx_wake(ctx_wake), .cmd_addr(cmd_addr), .cmd_z(cmd_z)
  );

  function automatic bit [31:0] exp_ctl();
    return {16'h0, m_run, 2'b00, m_wake, m_dead, m_act, 2'b00, m_spd, m_evt};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; reg_wdata = '0; hw_fetch = 1'b0; hw_fatal = 1'b0;
    pkt_stb = 1'b0;
  endtask

  // one clock of stimulus, then model update per R1,R2,R5..R9,R11
  task automatic step(bit wr, bit [1:0] a, bit [31:0] wd, bit fetch, bit fatal,
                      bit busy, bit stb, bit [2:0] spd, bit [4:0] evt);
    bit setw, clrw, setr, clrr;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; hw_fetch = fetch;
    hw_fatal = fatal; hw_busy = busy; pkt_stb = stb; pkt_speed = spd;
    pkt_evt = evt;
    @(posedge clk);
    setr = wr && a == 2'd0 && wd[15];
    clrr = wr && a == 2'd1 && wd[15];
    setw = wr && a == 2'd0 && wd[12];
    clrw = wr && a == 2'd1 && wd[12];
    if (setr) m_run = 1'b1;
    if (clrr) m_run = 1'b0;
    m_wake = setw ? 1'b1 : ((clrw || fetch) ? 1'b0 : m_wake);
    m_dead = clrr ? 1'b0 : (fatal ? 1'b1 : m_dead);
    m_act  = busy;
    if (stb) begin m_spd = spd; m_evt = evt; end
    if (wr && a == 2'd3) m_ptr = wd;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(bit [1:0] a, bit [31:0] wd);
    step(1'b1, a, wd, 1'b0, 1'b0, hw_busy, 1'b0, 3'd0, 5'd0);
  endtask

  task automatic check_ctl(string req);
    logic [31:0] r0, r1;
    @(negedge clk); idle(); reg_addr = 2'd0; #1 r0 = reg_rdata;
    @(negedge clk); reg_addr = 2'd1; #1 r1 = reg_rdata;
    chk(req, "set-alias read", r0, exp_ctl());
    chk(req, "clear-alias read", r1, exp_ctl());
    chk(req, "run/wake pins", {30'h0, ctx_run, ctx_wake}, {30'h0, m_run, m_wake});
  endtask

  task automatic check_ptr(string req);
    @(negedge clk); idle(); reg_addr = 2'd3; #1;
    chk(req, "pointer read", reg_rdata, m_ptr);
    chk(req, "pointer pins", {cmd_addr, cmd_z}, m_ptr);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; hw_busy = 1'b0; pkt_speed = '0; pkt_evt = '0;
    idle();
    {m_run, m_wake, m_dead, m_act} = '0; m_spd = '0; m_evt = '0; m_ptr = '0;
    repeat (4) @(posedge clk);
    // R10: reset state, sampled while still in reset
    check_ctl("R10");
    check_ptr("R10");
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    check_ctl("R10");

    // R1/R2/R3/R6/R7/R8: sweep every mix of control bits with reserved bits at one
    for (int p = 0; p < 16; p++) begin
      bit [31:0] wd;
      wd = {16'hFFFF, p[3], 2'b11, p[2], p[1], p[0], 2'b11, 8'hFF};
      wr(2'd0, wd); check_ctl("R1");
      wr(2'd1, wd); check_ctl("R2");
    end
    wr(2'd0, 32'h0000_9000); check_ctl("R3");
    wr(2'd1, 32'h0000_1000); check_ctl("R2");
    wr(2'd0, 32'h0000_0000); check_ctl("R1");

    // R5: fetch against set and clear of wake, from wake = 1
    for (int c = 0; c < 8; c++) begin
      bit [31:0] wd;
      wr(2'd0, 32'h0000_1000);
      wd = c[1] ? 32'h0000_1000 : 32'h0;
      step(c[0] || c[1], c[2] ? 2'd1 : 2'd0, wd, c[0], 1'b0, 1'b0, 1'b0, 3'd0, 5'd0);
      check_ctl("R5");
    end

    // R6: fatal against a stop write, with run set first
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, 32'h0000_8000);
      step(c[1], 2'd1, 32'h0000_8000, 1'b0, c[0], 1'b0, 1'b0, 3'd0, 5'd0);
      check_ctl("R6");
      step(1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 5'd0);
      check_ctl("R6");
      wr(2'd0, 32'h0000_0800); check_ctl("R6");
      wr(2'd1, 32'h0000_0800); check_ctl("R6");
      wr(2'd1, 32'h0000_8000); check_ctl("R6");
    end

    // R4/R7: hardware events do not move run; active tracks busy
    for (int r = 0; r < 2; r++) begin
      wr(r[0] ? 2'd0 : 2'd1, 32'h0000_8000);
      step(1'b0, 2'd0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 5'd17);
      check_ctl("R4");
      step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0);
      check_ctl("R7");
      step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 5'd0);
      check_ctl("R7");
      wr(2'd1, 32'h0000_0400); check_ctl("R7");
    end
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0);
    check_ctl("R7");

    // R8: every speed and code pair, then non-strobe values are ignored
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 32; e++) begin
        step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, s[2:0], e[4:0]);
        check_ctl("R8");
      end
    end
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 5'd3);
    check_ctl("R8");
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 5'd3);
    check_ctl("R8");
    wr(2'd0, 32'h0000_00FF); check_ctl("R8");
    wr(2'd1, 32'h0000_00FF); check_ctl("R8");

    // R9: pointer contents, walking one, and isolation from alias writes
    check_ptr("R9");
    wr(2'd3, 32'h1234_5671); check_ptr("R9");
    wr(2'd3, 32'hFFFF_FFF0); check_ptr("R9");
    wr(2'd3, 32'h0000_000F); check_ptr("R9");
    for (int b = 0; b < 32; b++) begin
      wr(2'd3, 32'h1 << b); check_ptr("R9");
    end
    wr(2'd3, 32'hA5A5_5A51);
    wr(2'd0, 32'hFFFF_FFFF); check_ptr("R9");
    wr(2'd1, 32'hFFFF_FFFF); check_ptr("R9");
    check_ctl("R9");

    // R11: unused address reads zero and ignores writes
    wr(2'd0, 32'h0000_9000);
    wr(2'd2, 32'hFFFF_FFFF);
    @(negedge clk); idle(); reg_addr = 2'd2; #1;
    chk("R11", "gap read", reg_rdata, 32'h0);
    check_ctl("R11");
    check_ptr("R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(HALF * 2.0 * 150000.0);
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule